// File: doc/BRIEF.md
# Interleaved Streaming Variance Accumulator

This block watches a stream of signed fixed-point samples, one per clock at most, and gathers single-pass statistics about it without ever holding the stream back. The update loop is slowed by a power-of-two factor. Consecutive accepted samples are dealt round-robin into that many independent partial accumulators ("slots"). Each slot keeps an exact sample count, an exact signed sum and an exact sum of squares, and each is updated from the new sample and the slot's previous value.

On a flush request the block walks the slots in ascending order and emits one record per slot: the count, the sum and the sum of squared deviations from the slot mean. The deviation term is derived at readout as the sum of squares minus the floor of sum squared over count, using a bit-serial divider. The per-slot records are meant for a later pairwise merge step outside this block. A clear request empties every slot in a single cycle.

Top module: `stat_var_accum`

## Requirements
- R1: After reset the slot pointer is 0, every slot is empty, `busy` is low and `rec_valid` is low.
- R2: The k-th accepted sample (counting from reset or the last clear, starting at 0) goes to slot k mod SLOTS. A cycle with `in_valid` low does not move the slot pointer.
- R3: Each slot holds the exact count, the exact two's-complement sum and the exact sum of squares of its samples. A record reports the count and the sum unchanged.
- R4: For a slot with count c > 0, sum s and sum of squares q, the record's `rec_dev` equals q − floor(s²/c).
- R5: A flush accepted while idle emits exactly SLOTS records, one per cycle of `rec_valid`, with `rec_slot` running 0, 1, …, SLOTS−1. `busy` is high from the cycle after the flush until after the last record.
- R6: A slot with count zero reports count 0, sum 0 and deviation 0.
- R7: A flush raised while `busy` is high is ignored. The readout in progress neither restarts nor emits extra records.
- R8: `clr` empties all slots, returns the pointer to 0 and aborts any readout, all in one cycle. `busy` and `rec_valid` are low in the next cycle. A sample presented in the same cycle as `clr` is dropped.
- R9: A sample is accepted in every cycle that `in_valid` is high, back-to-back, with no ready signal.
- R10: Reading out one slot takes no more than 2·SUM_W + 4 cycles, so a full readout is bounded by SLOTS times that figure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Empty all slots, reset the pointer, abort readout |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | DATA_W | Signed sample |
| flush | input | 1 | Start a readout of all slots (ignored while busy) |
| busy | output | 1 | Readout in progress |
| rec_valid | output | 1 | A record is presented this cycle |
| rec_slot | output | $clog2(SLOTS) | Slot index of the record |
| rec_count | output | MAX_LOG+1 | Samples in the slot |
| rec_sum | output | DATA_W+MAX_LOG | Signed sum of the slot's samples |
| rec_dev | output | 2·DATA_W+MAX_LOG−1 | Sum of squared deviations from the slot mean |

## Verification
The bench spreads a mixed stream across the slots, with gaps in `in_valid` and full-scale values of both signs. A pointer that moved on idle cycles would put every later sample one slot off, and a squaring or sign slip would corrupt the sum or the deviation of the slot holding the most negative value. Slots left empty after a clear must come out as all zeros; a design that divided by a zero count would report junk there. A second flush during readout must not restart the walk, which would show up as repeated slot indices or too many records. A clear in mid-readout must stop the records at once, and a sample presented in the same cycle as a clear must not land in slot 0.

// File: rtl/stat_var_pkg.sv
package stat_var_pkg;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_LOAD,
    RD_START,
    RD_DIV
  } rd_state_e;

endpackage

// File: rtl/stat_slot_bank.sv
module stat_slot_bank #(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 128,
  parameter int CNT_W  = 25,
  parameter int SUM_W  = 40,
  parameter int SQ_W   = 55
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic [$clog2(SLOTS)-1:0] rd_idx,
  output logic [CNT_W-1:0]        rd_cnt,
  output logic signed [SUM_W-1:0] rd_sum,
  output logic [SQ_W-1:0]         rd_sq
);
  localparam int PTR_W = $clog2(SLOTS);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  logic [CNT_W-1:0]        cnt_a [SLOTS];
  logic signed [SUM_W-1:0] sum_a [SLOTS];
  logic [SQ_W-1:0]         sq_a  [SLOTS];

  logic signed [2*DATA_W-1:0] prod;
  logic signed [SUM_W-1:0]    sum_inc;
  logic [SQ_W-1:0]            sq_inc;

  assign prod    = in_data * in_data;
  assign sum_inc = {{(SUM_W-DATA_W){in_data[DATA_W-1]}}, in_data};
  assign sq_inc  = {{(SQ_W-2*DATA_W){1'b0}}, prod};

  // Slot pointer: next-state and register processes
  always_comb begin
    ptr_en = clr | in_valid;
    ptr_d  = clr ? '0 : ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic                    hit, en;
    logic [CNT_W-1:0]        cnt_q, cnt_d;
    logic signed [SUM_W-1:0] sum_q, sum_d;
    logic [SQ_W-1:0]         sq_q, sq_d;

    always_comb begin
      hit = in_valid && (ptr_q == PTR_W'(g));
      en  = clr | hit;
      if (clr) begin
        cnt_d = '0;
        sum_d = '0;
        sq_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
        sum_d = sum_q + sum_inc;
        sq_d  = sq_q + sq_inc;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        sum_q <= '0;
        sq_q  <= '0;
      end else if (en) begin
        cnt_q <= cnt_d;
        sum_q <= sum_d;
        sq_q  <= sq_d;
      end
    end

    assign cnt_a[g] = cnt_q;
    assign sum_a[g] = sum_q;
    assign sq_a[g]  = sq_q;
  end

  assign rd_cnt = cnt_a[rd_idx];
  assign rd_sum = sum_a[rd_idx];
  assign rd_sq  = sq_a[rd_idx];

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(ptr_q)); // R2
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !clr && (&cnt_a[ptr_q]))); // R3
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_q == '0) && (cnt_a[0] == '0) && (sq_a[SLOTS-1] == '0)); // R8

endmodule

// File: rtl/stat_seq_div.sv
module stat_seq_div #(
  parameter int DVD_W = 80,
  parameter int DSR_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DSR_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);
  localparam int STEP_W = $clog2(DVD_W + 1);

  logic             run_q, run_d, done_q, done_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [DVD_W-1:0] dvd_q, dvd_d, quo_q, quo_d;
  logic [DSR_W-1:0] rem_q, rem_d, dsr_q, dsr_d;
  logic [DSR_W:0]   rem_sh, rem_sub;
  logic             fits;

  always_comb begin
    rem_sh  = {rem_q, dvd_q[DVD_W-1]};
    fits    = rem_sh >= {1'b0, dsr_q};
    rem_sub = rem_sh - {1'b0, dsr_q};

    run_d  = run_q;
    done_d = 1'b0;
    step_d = step_q;
    dvd_d  = dvd_q;
    quo_d  = quo_q;
    rem_d  = rem_q;
    dsr_d  = dsr_q;
    if (abort) begin
      run_d = 1'b0;
    end else if (start) begin
      run_d  = 1'b1;
      step_d = STEP_W'(DVD_W);
      dvd_d  = dividend;
      quo_d  = '0;
      rem_d  = '0;
      dsr_d  = divisor;
    end else if (run_q) begin
      rem_d  = fits ? rem_sub[DSR_W-1:0] : rem_sh[DSR_W-1:0];
      quo_d  = {quo_q[DVD_W-2:0], fits};
      dvd_d  = {dvd_q[DVD_W-2:0], 1'b0};
      step_d = step_q - STEP_W'(1);
      if (step_q == STEP_W'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dsr_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      step_q <= step_d;
      dvd_q  <= dvd_d;
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      dsr_q  <= dsr_d;
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;

  AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rem_q < dsr_q)); // R4
  AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !abort) |-> !start); // R10

endmodule

// File: rtl/stat_readout.sv
module stat_readout
  import stat_var_pkg::*;
#(
  parameter int SLOTS = 128,
  parameter int CNT_W = 25,
  parameter int SUM_W = 40,
  parameter int SQ_W  = 55
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     flush,
  output logic [$clog2(SLOTS)-1:0] rd_idx,
  input  logic [CNT_W-1:0]         rd_cnt,
  input  logic signed [SUM_W-1:0]  rd_sum,
  input  logic [SQ_W-1:0]          rd_sq,
  output logic                     busy,
  output logic                     rec_valid,
  output logic [$clog2(SLOTS)-1:0] rec_slot,
  output logic [CNT_W-1:0]         rec_count,
  output logic signed [SUM_W-1:0]  rec_sum,
  output logic [SQ_W-1:0]          rec_dev
);
  localparam int PTR_W = $clog2(SLOTS);
  localparam int DVD_W = 2 * SUM_W;
  localparam int BOUND = DVD_W + 4;
  localparam int CYC_W = $clog2(BOUND + 2);

  rd_state_e st_q, st_d;
  logic [PTR_W-1:0]        idx_q, idx_d;
  logic [CNT_W-1:0]        lc_q, lc_d;
  logic signed [SUM_W-1:0] ls_q, ls_d;
  logic [SQ_W-1:0]         lq_q, lq_d;
  logic                    rv_q, rv_d;
  logic [PTR_W-1:0]        rs_q, rs_d;
  logic [CNT_W-1:0]        rc_q, rc_d;
  logic signed [SUM_W-1:0] rsum_q, rsum_d;
  logic [SQ_W-1:0]         rdev_q, rdev_d;
  logic [CYC_W-1:0]        cyc_q, cyc_d;
  logic                    adv, div_start, div_done;
  logic [SUM_W-1:0]        mag;
  logic [DVD_W-1:0]        sq_s, quo;

  assign mag  = ls_q[SUM_W-1] ? SUM_W'(-ls_q) : SUM_W'(ls_q);
  assign sq_s = {{SUM_W{1'b0}}, mag} * {{SUM_W{1'b0}}, mag};

  stat_seq_div #(.DVD_W(DVD_W), .DSR_W(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (clr),
    .start    (div_start),
    .dividend (sq_s),
    .divisor  (lc_q),
    .done     (div_done),
    .quotient (quo)
  );

  always_comb begin
    st_d = st_q;  idx_d = idx_q;
    lc_d = lc_q;  ls_d = ls_q;  lq_d = lq_q;
    rv_d = 1'b0;  rs_d = rs_q;  rc_d = rc_q;
    rsum_d = rsum_q;  rdev_d = rdev_q;
    adv = 1'b0;  div_start = 1'b0;
    if (clr) begin
      st_d  = RD_IDLE;
      idx_d = '0;
    end else begin
      case (st_q)
        RD_IDLE: if (flush) begin
          st_d  = RD_LOAD;
          idx_d = '0;
        end
        RD_LOAD: begin
          lc_d = rd_cnt;  ls_d = rd_sum;  lq_d = rd_sq;
          if (rd_cnt == '0) begin
            rv_d = 1'b1;  rs_d = idx_q;  rc_d = '0;
            rsum_d = '0;  rdev_d = '0;  adv = 1'b1;
          end else begin
            st_d = RD_START;
          end
        end
        RD_START: begin
          div_start = 1'b1;
          st_d      = RD_DIV;
        end
        RD_DIV: if (div_done) begin
          rv_d = 1'b1;  rs_d = idx_q;  rc_d = lc_q;
          rsum_d = ls_q;  rdev_d = lq_q - quo[SQ_W-1:0];  adv = 1'b1;
        end
        default: st_d = RD_IDLE;
      endcase
      if (adv) begin
        if (idx_q == PTR_W'(SLOTS - 1)) st_d = RD_IDLE;
        else begin
          idx_d = idx_q + PTR_W'(1);
          st_d  = RD_LOAD;
        end
      end
    end
    cyc_d = (st_q == RD_IDLE || rv_d || clr) ? '0 : cyc_q + CYC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RD_IDLE;  idx_q <= '0;
      lc_q <= '0;  ls_q <= '0;  lq_q <= '0;
      rv_q <= 1'b0;  rs_q <= '0;  rc_q <= '0;
      rsum_q <= '0;  rdev_q <= '0;  cyc_q <= '0;
    end else begin
      st_q <= st_d;  idx_q <= idx_d;
      lc_q <= lc_d;  ls_q <= ls_d;  lq_q <= lq_d;
      rv_q <= rv_d;  rs_q <= rs_d;  rc_q <= rc_d;
      rsum_q <= rsum_d;  rdev_q <= rdev_d;  cyc_q <= cyc_d;
    end
  end

  assign rd_idx    = idx_q;
  assign busy      = (st_q != RD_IDLE);
  assign rec_valid = rv_q;
  assign rec_slot  = rs_q;
  assign rec_count = rc_q;
  assign rec_sum   = rsum_q;
  assign rec_dev   = rdev_q;

  AST_DEV_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RD_DIV && div_done) |-> (quo <= DVD_W'(lq_q))); // R4
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && rc_q == '0) |-> (rsum_q == '0 && rdev_q == '0)); // R6
  AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= CYC_W'(BOUND)); // R10
  AST_CLR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && !rec_valid)); // R8

endmodule

// File: rtl/stat_var_accum.sv
module stat_var_accum #(
  parameter int DATA_W  = 16,
  parameter int SLOTS   = 128,
  parameter int MAX_LOG = 24,
  localparam int PTR_W  = $clog2(SLOTS),
  localparam int CNT_W  = MAX_LOG + 1,
  localparam int SUM_W  = DATA_W + MAX_LOG,
  localparam int SQ_W   = 2 * DATA_W + MAX_LOG - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     flush,
  output logic                     busy,
  output logic                     rec_valid,
  output logic [PTR_W-1:0]         rec_slot,
  output logic [CNT_W-1:0]         rec_count,
  output logic signed [SUM_W-1:0]  rec_sum,
  output logic [SQ_W-1:0]          rec_dev
);
  logic rst_s0_q, rst_s1_q, rst_n_int;
  logic [PTR_W-1:0]        rd_idx;
  logic [CNT_W-1:0]        rd_cnt;
  logic signed [SUM_W-1:0] rd_sum;
  logic [SQ_W-1:0]         rd_sq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q <= 1'b0;
      rst_s1_q <= 1'b0;
    end else begin
      rst_s0_q <= 1'b1;
      rst_s1_q <= rst_s0_q;
    end
  end
  assign rst_n_int = rst_s1_q;

  stat_slot_bank #(
    .DATA_W(DATA_W), .SLOTS(SLOTS), .CNT_W(CNT_W), .SUM_W(SUM_W), .SQ_W(SQ_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (clr),
    .in_valid (in_valid),
    .in_data  (in_data),
    .rd_idx   (rd_idx),
    .rd_cnt   (rd_cnt),
    .rd_sum   (rd_sum),
    .rd_sq    (rd_sq)
  );

  stat_readout #(
    .SLOTS(SLOTS), .CNT_W(CNT_W), .SUM_W(SUM_W), .SQ_W(SQ_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr       (clr),
    .flush     (flush),
    .rd_idx    (rd_idx),
    .rd_cnt    (rd_cnt),
    .rd_sum    (rd_sum),
    .rd_sq     (rd_sq),
    .busy      (busy),
    .rec_valid (rec_valid),
    .rec_slot  (rec_slot),
    .rec_count (rec_count),
    .rec_sum   (rec_sum),
    .rec_dev   (rec_dev)
  );

endmodule

// File: tb/stat_var_accum_bench.sv
module stat_var_accum_bench;
  localparam int DATA_W  = 16;
  localparam int SLOTS   = 8;
  localparam int MAX_LOG = 24;
  localparam int PTR_W   = $clog2(SLOTS);
  localparam int CNT_W   = MAX_LOG + 1;
  localparam int SUM_W   = DATA_W + MAX_LOG;
  localparam int SQ_W    = 2 * DATA_W + MAX_LOG - 1;
  localparam int NVEC    = 24;
  localparam int FULL_BOUND = SLOTS * (2 * SUM_W + 4) + 4;

  // {valid, sample}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 16'd5},     {1'b1, 16'hfffd}, {1'b1, 16'd100},  {1'b1, 16'h8000},
    {1'b0, 16'd999},   {1'b1, 16'h7fff}, {1'b1, 16'd0},    {1'b1, 16'hffff},
    {1'b1, 16'd7},     {1'b1, 16'd7},    {1'b1, 16'hff38}, {1'b0, 16'hfffb},
    {1'b1, 16'd12345}, {1'b1, 16'hcfc7}, {1'b1, 16'd1},    {1'b1, 16'd2},
    {1'b1, 16'h8000},  {1'b1, 16'h8000}, {1'b0, 16'd0},    {1'b1, 16'd300},
    {1'b1, 16'hfff9},  {1'b1, 16'd64},   {1'b1, 16'hffc0}, {1'b0, 16'd8}
  };

  logic clk, rst_n, clr, in_valid, flush;
  logic signed [DATA_W-1:0] in_data;
  logic busy, rec_valid;
  logic [PTR_W-1:0] rec_slot;
  logic [CNT_W-1:0] rec_count;
  logic signed [SUM_W-1:0] rec_sum;
  logic [SQ_W-1:0] rec_dev;

  stat_var_accum #(.DATA_W(DATA_W), .SLOTS(SLOTS), .MAX_LOG(MAX_LOG)) u_stat_var_accum (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_data(in_data),
    .flush(flush), .busy(busy), .rec_valid(rec_valid), .rec_slot(rec_slot),
    .rec_count(rec_count), .rec_sum(rec_sum), .rec_dev(rec_dev)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  longint m_cnt [SLOTS], m_sum [SLOTS], m_sq [SLOTS];
  int m_ptr;
  int rec_total;
  longint g_slot [32], g_cnt [32], g_sum [32], g_dev [32];

  always @(negedge clk) begin
    if (rec_valid) begin
      if (rec_total < 32) begin
        g_slot[rec_total] = longint'(rec_slot);
        g_cnt[rec_total]  = longint'(rec_count);
        g_sum[rec_total]  = longint'(rec_sum);
        g_dev[rec_total]  = longint'(rec_dev);
      end
      rec_total++;
    end
  end

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < SLOTS; i++) begin
      m_cnt[i] = 0; m_sum[i] = 0; m_sq[i] = 0;
    end
    m_ptr = 0;
  endtask

  task automatic send(input logic v, input logic [15:0] d);
    in_valid = v; in_data = d;
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (v) begin
      longint x = longint'($signed(d));
      m_cnt[m_ptr] += 1; m_sum[m_ptr] += x; m_sq[m_ptr] += x * x;
      m_ptr = (m_ptr + 1) % SLOTS;
    end
  endtask

  task automatic pulse_clr();
    clr = 1'b1; @(posedge clk); #1; clr = 1'b0;
  endtask

  task automatic pulse_flush();
    flush = 1'b1; @(posedge clk); #1; flush = 1'b0;
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy && cycles < FULL_BOUND * 2) begin
      @(posedge clk); #1; cycles++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic compare_records(input string tag);
    check({tag, " R5 record total"}, rec_total, SLOTS);
    for (int i = 0; i < SLOTS && i < 32; i++) begin
      longint e_dev = 0;
      if (m_cnt[i] != 0) begin
        longint a = (m_sum[i] < 0) ? -m_sum[i] : m_sum[i];
        e_dev = m_sq[i] - (a * a) / m_cnt[i];
      end
      check({tag, " R5 slot order"}, g_slot[i], i);
      check({tag, " R3 count"}, g_cnt[i], m_cnt[i]);
      check({tag, " R3 sum"}, g_sum[i], m_sum[i]);
      check({tag, " R4 deviation"}, g_dev[i], e_dev);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; flush = 1'b0; in_data = '0;
    model_clear();
    rec_total = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1: reset state
    check("R1 busy after reset", longint'(busy), 0);
    check("R1 rec_valid after reset", longint'(rec_valid), 0);
    rec_total = 0;
    pulse_flush();
    check("R5 busy after flush", longint'(busy), 1);
    wait_idle(cyc);
    compare_records("R1 R6 empty after reset");

    // Vector table: R2, R3, R4, R9 (back-to-back valid samples)
    for (int k = 0; k < NVEC; k++) send(VEC[k][16], VEC[k][15:0]);
    rec_total = 0;
    pulse_flush();
    wait_idle(cyc);
    compare_records("R2 R9 table");
    check("R10 readout bound", longint'(cyc <= FULL_BOUND), 1);

    // R7: second flush while busy is ignored
    rec_total = 0;
    pulse_flush();
    repeat (100) @(posedge clk);
    #1;
    check("R7 busy before second flush", longint'(busy), 1);
    pulse_flush();
    wait_idle(cyc);
    repeat (20) @(posedge clk);
    #1;
    compare_records("R7 refused flush");

    // R8: clear mid-readout aborts
    pulse_flush();
    repeat (10) @(posedge clk);
    #1;
    pulse_clr();
    model_clear();
    check("R8 busy after clear", longint'(busy), 0);
    check("R8 rec_valid after clear", longint'(rec_valid), 0);

    // R8: sample with clear in same cycle is dropped
    in_valid = 1'b1; in_data = 16'sd77; clr = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; clr = 1'b0;
    for (int k = 0; k < 5; k++) send(1'b1, 16'(k * 3 - 4));
    rec_total = 0;
    pulse_flush();
    wait_idle(cyc);
    compare_records("R8 R6 R2 after clear");
    check("R6 empty slot count", g_cnt[SLOTS-1], 0);
    check("R8 slot0 holds first post-clear sample", g_sum[0], -4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule